// File: doc/BRIEF.md
# Modulation-Indexed Switching Angle Table

This block holds a precomputed table of inverter switching angles and, on request, plays back the nine angles that belong to one modulation index. The caller presents an index code together with a one-cycle valid strobe. The block then walks a single synchronous memory port through the nine angle groups, one group per clock. Each word comes out with its angle number, and the ninth word carries an end marker. It does not use nine parallel tables.

The index code covers a modulation index from 0.48 upward in steps of 0.001, with code 0 standing for 0.48. Only 512 steps are stored for each angle, so any code above 511 reads entry 511. The memory is laid out group by group, and its contents are computed at elaboration by a generator function. Nothing is loaded from a file.

The sequencer has three named states. IDLE waits for a request. FETCH issues one memory read per cycle for groups 0 to 8. FLUSH is the single cycle that lets the last read drain while the end marker is shown. The transitions are:
- IDLE→FETCH on an accepted request.
- FETCH→FETCH while the group counter is below 8.
- FETCH→FLUSH when group 8 is issued.
- FLUSH→IDLE unconditionally.
- Any state→IDLE on reset.

Top module: `angle_table_seq`

## Requirements
- R1: A clock edge with `rst` high forces `busy`, `out_valid` and `out_last` low, `out_tag` to 0 and `out_angle` to 0 from the next cycle on.
- R2: A `req_valid` sampled high while `busy` is low is accepted at that edge, and `busy` is high from the next cycle through the cycle in which `out_last` is high.
- R3: `out_valid` first goes high one cycle after `busy` rises and then stays high for exactly 9 consecutive cycles per request.
- R4: During a burst, `out_tag` counts 0, 1, …, 8 in consecutive cycles. `out_last` is high only together with tag 8.
- R5: The word for angle g at stored index i equals ((g+1)·3600 + i·(g+3)) truncated to `ANGLE_W` bits, with g in 0..8 and i in 0..511.
- R6: The memory is group-major: angle g of index i lives at address g·512 + i, and every word of a burst comes from the group given by its tag.
- R7: An index code above 511 returns the same nine words as code 511.
- R8: `req_valid` is ignored while `busy` is high, including the cycle that shows `out_last`. Such a request adds no output cycles.
- R9: While `out_valid` is low, `out_angle` and `out_tag` hold their last values.
- R10: `busy` is low in the cycle right after `out_last`, so a request presented in that cycle starts a new burst with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock, driven from the board oscillator |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled only while idle |
| req_index | input | REQ_W (10) | Modulation index code, 0 means 0.48, clamped at 511 |
| busy | output | 1 | High from acceptance through the end-marker cycle |
| out_valid | output | 1 | An angle word is present on `out_angle` |
| out_last | output | 1 | Marks the ninth word of a burst |
| out_tag | output | GRP_W (4) | Angle number of the present word, 0 to 8 |
| out_angle | output | ANGLE_W (16) | Switching angle, unsigned fixed-point degrees |

## Verification
Take the edge that accepts a request as edge 0. `busy` is high after edge 0. Tag 0 and its word appear after edge 1, and tags then advance one per edge until tag 8 with `out_last` appears after edge 9. `busy` and `out_valid` drop after edge 10. The bench therefore pushes the nine expected words when it drives a request. A monitor samples on the falling edge and pops one item for each cycle in which `out_valid` is high, so any early, late, missing or extra word shows up as a mismatch or an empty-queue pop. The monitor also checks that `busy` is high one falling edge after a request, that `busy` is low one falling edge after `out_last`, and that idle stretches leave the outputs unchanged.

// File: rtl/angle_table_pkg.sv
package angle_table_pkg;

    // Contents generator, shared by the ROM initialisation.
    localparam int unsigned GROUP_BASE_STEP = 3600;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_FLUSH = 2'd2
    } seq_state_t;

    function automatic int unsigned angle_word(input int unsigned grp, input int unsigned idx);
        return (grp + 1) * GROUP_BASE_STEP + idx * (grp + 3);
    endfunction

endpackage

// File: rtl/angle_index_clamp.sv
module angle_index_clamp #(
    parameter int REQ_W = 10,
    parameter int IDX_W = 9
) (
    input  logic [REQ_W-1:0] code_in,
    output logic [IDX_W-1:0] idx_out
);
    localparam logic [REQ_W-1:0] MAX_CODE = REQ_W'((1 << IDX_W) - 1);

    always_comb begin
        if (code_in > MAX_CODE) begin
            idx_out = IDX_W'(MAX_CODE);
        end else begin
            idx_out = IDX_W'(code_in);
        end
    end
endmodule

// File: rtl/angle_addr_gen.sv
module angle_addr_gen #(
    parameter int NUM_GROUPS = 9,
    parameter int IDX_W      = 9,
    parameter int GRP_W      = $clog2(NUM_GROUPS),
    parameter int ADDR_W     = $clog2(NUM_GROUPS << IDX_W)
) (
    input  logic [GRP_W-1:0]  grp,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    localparam int unsigned GROUP_DEPTH = 1 << IDX_W;

    // Group-major layout: each angle owns one contiguous block of GROUP_DEPTH words.
    always_comb begin
        addr = ADDR_W'(grp) * ADDR_W'(GROUP_DEPTH) + ADDR_W'(idx);
    end
endmodule

// File: rtl/angle_rom.sv
module angle_rom #(
    parameter int ANGLE_W    = 16,
    parameter int NUM_GROUPS = 9,
    parameter int IDX_W      = 9,
    parameter int ADDR_W     = $clog2(NUM_GROUPS << IDX_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [ANGLE_W-1:0] rd_data
);
    import angle_table_pkg::*;

    localparam int unsigned DEPTH       = NUM_GROUPS << IDX_W;
    localparam int unsigned GROUP_DEPTH = 1 << IDX_W;

    logic [ANGLE_W-1:0] mem [DEPTH];

    initial begin
        for (int unsigned k = 0; k < DEPTH; k++) begin
            mem[k] = ANGLE_W'(angle_word(k / GROUP_DEPTH, k % GROUP_DEPTH));
        end
    end

    // One-cycle read latency; the word holds when no read is issued.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/angle_seq_fsm.sv
module angle_seq_fsm #(
    parameter int NUM_GROUPS = 9,
    parameter int IDX_W      = 9,
    parameter int GRP_W      = $clog2(NUM_GROUPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_idx,
    output logic             rd_en,
    output logic [GRP_W-1:0] grp,
    output logic [IDX_W-1:0] idx_q,
    output logic             busy,
    output logic             out_valid,
    output logic             out_last,
    output logic [GRP_W-1:0] out_tag
);
    import angle_table_pkg::*;

    localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(NUM_GROUPS - 1);

    seq_state_t state, state_nx;
    logic       accept;
    logic       issue_last;

    assign accept     = (state == ST_IDLE) && req_valid;
    assign issue_last = (state == ST_FETCH) && (grp == LAST_GRP);
    assign rd_en      = (state == ST_FETCH);
    assign busy       = (state != ST_IDLE);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = ST_FETCH;
            ST_FETCH: if (grp == LAST_GRP) state_nx = ST_FLUSH;
            ST_FLUSH: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register, request capture and group counter.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            grp   <= '0;
            idx_q <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                idx_q <= req_idx;
                grp   <= '0;
            end else if (rd_en && !issue_last) begin
                grp <= grp + 1'b1;
            end
        end
    end

    // Output flags, aligned with the one-cycle memory read.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_tag   <= '0;
        end else begin
            out_valid <= rd_en;
            out_last  <= issue_last;
            if (rd_en) begin
                out_tag <= grp;
            end
        end
    end
endmodule

// File: rtl/angle_table_seq.sv
module angle_table_seq #(
    parameter int ANGLE_W    = 16,
    parameter int NUM_GROUPS = 9,
    parameter int IDX_W      = 9,
    parameter int REQ_W      = 10,
    parameter int GRP_W      = $clog2(NUM_GROUPS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [REQ_W-1:0]   req_index,
    output logic               busy,
    output logic               out_valid,
    output logic               out_last,
    output logic [GRP_W-1:0]   out_tag,
    output logic [ANGLE_W-1:0] out_angle
);
    localparam int ADDR_W = $clog2(NUM_GROUPS << IDX_W);

    logic [IDX_W-1:0]  clamped_idx;
    logic [IDX_W-1:0]  held_idx;
    logic [GRP_W-1:0]  cur_grp;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_en;

    angle_index_clamp #(.REQ_W(REQ_W), .IDX_W(IDX_W)) u_clamp (
        .code_in (req_index),
        .idx_out (clamped_idx)
    );

    angle_seq_fsm #(.NUM_GROUPS(NUM_GROUPS), .IDX_W(IDX_W), .GRP_W(GRP_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_idx   (clamped_idx),
        .rd_en     (rd_en),
        .grp       (cur_grp),
        .idx_q     (held_idx),
        .busy      (busy),
        .out_valid (out_valid),
        .out_last  (out_last),
        .out_tag   (out_tag)
    );

    angle_addr_gen #(.NUM_GROUPS(NUM_GROUPS), .IDX_W(IDX_W), .GRP_W(GRP_W), .ADDR_W(ADDR_W)) u_addr (
        .grp  (cur_grp),
        .idx  (held_idx),
        .addr (rd_addr)
    );

    angle_rom #(.ANGLE_W(ANGLE_W), .NUM_GROUPS(NUM_GROUPS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_rom (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (out_angle)
    );
endmodule

// File: rtl/angle_table_chk.sv
module angle_table_chk #(
    parameter int ANGLE_W    = 16,
    parameter int NUM_GROUPS = 9,
    parameter int GRP_W      = $clog2(NUM_GROUPS)
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               busy,
    input logic               out_valid,
    input logic               out_last,
    input logic [GRP_W-1:0]   out_tag,
    input logic [ANGLE_W-1:0] out_angle
);
    localparam logic [GRP_W-1:0] LAST_TAG = GRP_W'(NUM_GROUPS - 1);

    a_r1_reset_idle: assert property (@(posedge clk) rst |=> !busy && !out_valid && !out_last);

    a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid) |=> busy);

    a_r2_busy_covers_outputs: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> busy);

    a_r3_valid_follows_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> $rose(out_valid));

    a_r4_first_tag_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (out_tag == '0));

    a_r4_tag_steps: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> out_valid && (out_tag == GRP_W'($past(out_tag) + 1'b1)));

    a_r4_last_on_final_tag: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid && (out_tag == LAST_TAG));

    a_r10_free_after_last: assert property (@(posedge clk) disable iff (rst)
        out_last |=> !busy && !out_valid);

    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(out_angle) && $stable(out_tag));
endmodule

bind angle_table_seq angle_table_chk #(
    .ANGLE_W    (ANGLE_W),
    .NUM_GROUPS (NUM_GROUPS),
    .GRP_W      (GRP_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .busy      (busy),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_tag   (out_tag),
    .out_angle (out_angle)
);

// File: tb/tb_angle_table_seq.sv
module tb_angle_table_seq;
    localparam int ANGLE_W = 16;
    localparam int NGRP    = 9;
    localparam int IDX_W   = 9;
    localparam int REQ_W   = 10;
    localparam int GRP_W   = 4;

    typedef struct packed {
        logic [GRP_W-1:0]   tag;
        logic [ANGLE_W-1:0] angle;
        logic               last;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               req_valid = 1'b0;
    logic [REQ_W-1:0]   req_index = '0;
    logic               busy, out_valid, out_last;
    logic [GRP_W-1:0]   out_tag;
    logic [ANGLE_W-1:0] out_angle;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int run_len = 0;
    logic prev_valid = 1'b0;
    logic prev_last = 1'b0;
    logic mon_on = 1'b0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    angle_table_seq dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_index(req_index),
        .busy(busy), .out_valid(out_valid), .out_last(out_last),
        .out_tag(out_tag), .out_angle(out_angle)
    );

    function automatic logic [ANGLE_W-1:0] model(input int g, input int code);
        int i;
        i = (code > 511) ? 511 : code;  // R7 clamp
        return ANGLE_W'((g + 1) * 3600 + i * (g + 3));  // R5, R6
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: waits for idle, strobes one request, pushes the expected burst.
    task automatic send(input int code);
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid = 1'b1;
        req_index = REQ_W'(code);
        for (int g = 0; g < NGRP; g++) begin
            sb.push_back('{tag: GRP_W'(g), angle: model(g, code), last: (g == NGRP - 1)});
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(busy === 1'b1, "R2 busy after accept", busy, 1);
    endtask

    // Monitor: scoreboard pops and burst-shape checks.
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                run_len++;
                if (sb.size() == 0) begin
                    check(1'b0, "R8 unexpected output word", out_tag, -1);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(out_tag == e.tag, "R4 tag order", out_tag, e.tag);
                    check(out_angle == e.angle, "R5 R6 R7 angle word", out_angle, e.angle);
                    check(out_last == e.last, "R4 last marker", out_last, e.last);
                end
            end else if (prev_valid) begin
                check(run_len == NGRP, "R3 burst length", run_len, NGRP);
                run_len = 0;
            end
            if (prev_last) check(busy === 1'b0, "R10 idle after last", busy, 0);
        end
        prev_valid = out_valid;
        prev_last  = out_last;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [ANGLE_W-1:0] held_a;
        logic [GRP_W-1:0]   held_t;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 0 && out_valid == 0 && out_last == 0, "R1 reset flags", {busy, out_valid, out_last}, 0);
        check(out_angle == 0 && out_tag == 0, "R1 reset data", out_angle, 0);
        mon_on = 1'b1;

        send(0);
        send(1);
        send(100);
        send(511);
        send(512);   // R7
        send(1023);  // R7
        send(520);   // R7
        // Back-to-back starts come from send() seeing busy low right after out_last (R10).

        // R8: keep req_valid high with other codes through one whole burst.
        send(37);
        req_valid = 1'b1;
        while (busy) begin
            req_index = REQ_W'(200 + cycles % 50);
            @(negedge clk);
        end
        req_valid = 1'b0;

        // R9: outputs hold during an idle stretch.
        @(negedge clk);
        held_a = out_angle;
        held_t = out_tag;
        repeat (15) @(negedge clk);
        check(out_angle == held_a, "R9 angle holds", out_angle, held_a);
        check(out_tag == held_t, "R9 tag holds", out_tag, held_t);
        check(out_valid == 0 && busy == 0, "R8 no extra burst", {out_valid, busy}, 0);

        send(255);
        while (busy || sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R3 all words seen", sb.size(), 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule